// File: doc/BRIEF.md
# Dual-Descriptor Posted Read Engine

This block performs background reads from an external memory so the processor never stalls on them. Software loads one of two descriptor sets with a start address, an element size and a count. The engine then issues single reads on a request/acknowledge memory port, one at a time. Each returned word is pushed into an internal read FIFO, and the set's address moves forward by its element size.

The two sets form a ping-pong chain. When the running set's count runs out, the other set starts if it holds a nonzero count. Its results join the same FIFO stream. A set that has finished can be reloaded while its partner runs, which keeps reads flowing.

A FIFO fill threshold drives a DMA request and an interrupt. The engine stops issuing reads while the FIFO is full. Writing a zero count cancels a set. Any read already on the bus still completes and delivers its data first. Status outputs tell software when the cancel has settled. The live address registers let software work out how many reads finished.

Top module: `posted_rd_engine`

## Requirements
- R1: After reset, `mem_req`, `stat_active`, `stat_busy`, `fifo_level`, `fifo_underflow`, `irq` and `dma_req` are all zero.
- R2: A set reads from its start address and advances by 1, 2 or 4 after each completed read. The size field codes are 0 for byte, 1 for half-word and 2 (or 3) for word, and `mem_size` carries the code of the active set. The field code on `cfg_field` is 0 for address, 1 for size and 2 for count.
- R3: Each acknowledged read pushes `mem_rdata` into the FIFO in issue order. A pop in cycle T presents the oldest entry on `fifo_rdata` after the edge that ends cycle T.
- R4: No read is issued while `fifo_level` equals FIFO_DEPTH, and the set stays active. Issuing resumes after a pop frees an entry.
- R5: `dma_req` is high one edge after `fifo_level` is at or above a nonzero `fifo_thresh`, and low otherwise. `irq` is high under the same condition, and also whenever `fifo_underflow` is set.
- R6: When the active set's count reaches zero and the other set is armed (nonzero count), the other set runs next. Its data follows in the same FIFO order.
- R7: A finished set rewritten while the other set runs starts automatically once the running set completes.
- R8: Writing zero to the active set's count cancels it. An outstanding read still completes, pushes its data and advances the address. `stat_active` and `stat_busy` both stay high until that read is acknowledged, and no further read follows.
- R9: `mem_addr` carries address bits [28:0]. With `cs_multi` high, `mem_cs` equals address bits [31:29]. With `cs_multi` low, `mem_cs` is 3'b001.
- R10: At most one request is outstanding. `mem_req` stays high with stable `mem_addr` and `mem_size` until `mem_ack`.
- R11: A pop of an empty FIFO returns zero on `fifo_rdata` and sets `fifo_underflow`, which stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Descriptor field write strobe |
| cfg_set | input | 1 | Descriptor set index |
| cfg_field | input | 2 | Field select: 0 address, 1 size, 2 count |
| cfg_wdata | input | ADDR_W | Write data |
| cs_multi | input | 1 | Multi-chip-select mode |
| fifo_thresh | input | LVL_W | FIFO fill threshold (0 disables) |
| fifo_pop | input | 1 | Pop one FIFO entry |
| mem_ack | input | 1 | Read acknowledge, data valid |
| mem_rdata | input | DATA_W | Read data |
| mem_req | output | 1 | Read request |
| mem_addr | output | ADDR_W-3 | Bus address |
| mem_size | output | 2 | Element size code |
| mem_cs | output | 3 | Chip-select enables |
| fifo_rdata | output | DATA_W | Popped data |
| fifo_level | output | LVL_W | FIFO entry count |
| fifo_underflow | output | 1 | Sticky empty-pop flag |
| irq | output | 1 | Interrupt |
| dma_req | output | 1 | DMA request |
| stat_active | output | 2 | One bit per set, high while that set is selected |
| stat_busy | output | 1 | A read is outstanding |
| set0_addr | output | ADDR_W | Live address of set 0 |
| set1_addr | output | ADDR_W | Live address of set 1 |

## Verification
The hardest case to reach is a cancel that lands while a read is outstanding. The bench's memory model has a hold switch that withholds the acknowledge. The test arms a set and waits until `mem_req` is up. It then writes a zero count while the acknowledge is held back, and checks that active and busy both stay high and the address stays stable. After releasing the acknowledge, it checks that exactly one entry arrived and that the address moved by one step. Back-pressure is reached by arming more reads than the FIFO holds and then popping one entry at a time.

// File: rtl/prd_pkg.sv
package prd_pkg;
  typedef enum logic [1:0] {
    FLD_ADDR  = 2'd0,
    FLD_SIZE  = 2'd1,
    FLD_COUNT = 2'd2
  } fld_e;

  // size code -> byte step (code 3 behaves as word)
  function automatic logic [2:0] size_step(input logic [1:0] code);
    case (code)
      2'd0:    size_step = 3'd1;
      2'd1:    size_step = 3'd2;
      default: size_step = 3'd4;
    endcase
  endfunction
endpackage

// File: rtl/prd_desc.sv
module prd_desc #(
  parameter int AW = 32,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_addr,
  input  logic          wr_size,
  input  logic          wr_cnt,
  input  logic [AW-1:0] wdata,
  input  logic          done,
  output logic [AW-1:0] addr,
  output logic [1:0]    size,
  output logic          armed
);
  import prd_pkg::*;

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      addr <= '0;
      size <= 2'd0;
      cnt  <= '0;
    end else begin
      if (wr_addr)   addr <= wdata;
      else if (done) addr <= addr + AW'(size_step(size));
      if (wr_size)   size <= wdata[1:0];
      if (wr_cnt)    cnt  <= wdata[CW-1:0];
      else if (done && cnt != '0) cnt <= cnt - CW'(1);
    end
  end

  assign armed = (cnt != '0);
endmodule

// File: rtl/prd_fifo.sv
module prd_fifo #(
  parameter int DW    = 32,
  parameter int DEPTH = 8,
  localparam int PW   = $clog2(DEPTH),
  localparam int LW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic [DW-1:0] push_data,
  input  logic          pop,
  output logic [DW-1:0] rdata,
  output logic [LW-1:0] level,
  output logic          full,
  output logic          underflow
);
  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] wptr, rptr;
  logic          empty, push_ok, pop_ok;

  assign empty   = (level == '0);
  assign full    = (level == LW'(DEPTH));
  assign push_ok = push && !full;
  assign pop_ok  = pop && !empty;

  always_ff @(posedge clk) begin
    if (push_ok) mem[wptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr      <= '0;
      rptr      <= '0;
      level     <= '0;
      rdata     <= '0;
      underflow <= 1'b0;
    end else begin
      if (push_ok) wptr <= wptr + PW'(1);
      if (pop_ok) begin
        rptr  <= rptr + PW'(1);
        rdata <= mem[rptr];
      end else if (pop) begin
        rdata     <= '0;
        underflow <= 1'b1;
      end
      case ({push_ok, pop_ok})
        2'b10:   level <= level + LW'(1);
        2'b01:   level <= level - LW'(1);
        default: level <= level;
      endcase
    end
  end
endmodule

// File: rtl/posted_rd_engine.sv
module posted_rd_engine #(
  parameter int ADDR_W     = 32,
  parameter int CNT_W      = 16,
  parameter int DATA_W     = 32,
  parameter int FIFO_DEPTH = 8,
  localparam int LVL_W     = $clog2(FIFO_DEPTH + 1),
  localparam int BUS_AW    = ADDR_W - 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic              cfg_set,
  input  logic [1:0]        cfg_field,
  input  logic [ADDR_W-1:0] cfg_wdata,
  input  logic              cs_multi,
  input  logic [LVL_W-1:0]  fifo_thresh,
  input  logic              fifo_pop,
  input  logic              mem_ack,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              mem_req,
  output logic [BUS_AW-1:0] mem_addr,
  output logic [1:0]        mem_size,
  output logic [2:0]        mem_cs,
  output logic [DATA_W-1:0] fifo_rdata,
  output logic [LVL_W-1:0]  fifo_level,
  output logic              fifo_underflow,
  output logic              irq,
  output logic              dma_req,
  output logic [1:0]        stat_active,
  output logic              stat_busy,
  output logic [ADDR_W-1:0] set0_addr,
  output logic [ADDR_W-1:0] set1_addr
);
  import prd_pkg::*;

  logic [ADDR_W-1:0] addr_a  [2];
  logic [1:0]        size_a  [2];
  logic [1:0]        armed;
  logic              act, act_valid;
  logic              push, full, thr_hit;

  assign push = mem_req && mem_ack;

  for (genvar gi = 0; gi < 2; gi++) begin : g_set
    logic sel;
    assign sel = cfg_we && (cfg_set == 1'(gi));
    prd_desc #(.AW(ADDR_W), .CW(CNT_W)) u_set (
      .clk     (clk),
      .rst     (rst),
      .wr_addr (sel && cfg_field == FLD_ADDR),
      .wr_size (sel && cfg_field == FLD_SIZE),
      .wr_cnt  (sel && cfg_field == FLD_COUNT),
      .wdata   (cfg_wdata),
      .done    (push && act == 1'(gi)),
      .addr    (addr_a[gi]),
      .size    (size_a[gi]),
      .armed   (armed[gi])
    );
  end

  prd_fifo #(.DW(DATA_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk       (clk),
    .rst       (rst),
    .push      (push),
    .push_data (mem_rdata),
    .pop       (fifo_pop),
    .rdata     (fifo_rdata),
    .level     (fifo_level),
    .full      (full),
    .underflow (fifo_underflow)
  );

  // sequencer: select a set, issue one read, wait for its acknowledge
  always_ff @(posedge clk) begin
    if (rst) begin
      act       <= 1'b1;   // so set 0 is preferred first
      act_valid <= 1'b0;
      mem_req   <= 1'b0;
      mem_addr  <= '0;
      mem_size  <= 2'd0;
      mem_cs    <= 3'd0;
    end else if (mem_req) begin
      if (mem_ack) mem_req <= 1'b0;
    end else if (act_valid && armed[act]) begin
      if (!full) begin
        mem_req  <= 1'b1;
        mem_addr <= addr_a[act][BUS_AW-1:0];
        mem_size <= size_a[act];
        mem_cs   <= cs_multi ? addr_a[act][ADDR_W-1 -: 3] : 3'b001;
      end
    end else if (armed[~act]) begin
      act       <= ~act;
      act_valid <= 1'b1;
    end else begin
      act_valid <= armed[act];
    end
  end

  assign thr_hit = (fifo_thresh != '0) && (fifo_level >= fifo_thresh);

  always_ff @(posedge clk) begin
    if (rst) begin
      irq     <= 1'b0;
      dma_req <= 1'b0;
    end else begin
      dma_req <= thr_hit;
      irq     <= thr_hit || fifo_underflow;
    end
  end

  assign stat_active = act_valid ? (act ? 2'b10 : 2'b01) : 2'b00;
  assign stat_busy   = mem_req;
  assign set0_addr   = addr_a[0];
  assign set1_addr   = addr_a[1];
endmodule

// File: rtl/prd_chk.sv
module prd_chk #(
  parameter int BUS_AW     = 29,
  parameter int LVL_W      = 4,
  parameter int FIFO_DEPTH = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              mem_req,
  input logic              mem_ack,
  input logic [BUS_AW-1:0] mem_addr,
  input logic [1:0]        mem_size,
  input logic [LVL_W-1:0]  fifo_level,
  input logic              fifo_pop,
  input logic              fifo_underflow,
  input logic [1:0]        stat_active
);
  assert_req_held_R10: assert property (@(posedge clk) disable iff (rst)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_size));

  assert_no_issue_full_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_req) |-> $past(fifo_level) < LVL_W'(FIFO_DEPTH));

  assert_level_bound_R4: assert property (@(posedge clk) disable iff (rst)
    fifo_level <= LVL_W'(FIFO_DEPTH));

  assert_ack_pushes_R3: assert property (@(posedge clk) disable iff (rst)
    mem_req && mem_ack && !fifo_pop |=> fifo_level == $past(fifo_level) + LVL_W'(1));

  assert_one_set_R6: assert property (@(posedge clk) disable iff (rst)
    $onehot0(stat_active));

  assert_req_owned_R8: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> stat_active != 2'b00);

  assert_underflow_sticky_R11: assert property (@(posedge clk) disable iff (rst)
    fifo_underflow |=> fifo_underflow);
endmodule

bind posted_rd_engine prd_chk #(
  .BUS_AW(BUS_AW), .LVL_W(LVL_W), .FIFO_DEPTH(FIFO_DEPTH)
) u_chk (
  .clk(clk), .rst(rst), .mem_req(mem_req), .mem_ack(mem_ack),
  .mem_addr(mem_addr), .mem_size(mem_size), .fifo_level(fifo_level),
  .fifo_pop(fifo_pop), .fifo_underflow(fifo_underflow),
  .stat_active(stat_active)
);

// File: tb/tb_posted_rd_engine.sv
module tb_posted_rd_engine;
  localparam int LVL_W = 4;
  localparam logic [31:0] XMASK = 32'h5A5A_0000;

  logic        clk = 1'b0, rst = 1'b1;
  logic        cfg_we = 1'b0, cfg_set = 1'b0;
  logic [1:0]  cfg_field = 2'd0;
  logic [31:0] cfg_wdata = '0;
  logic        cs_multi = 1'b0;
  logic [LVL_W-1:0] fifo_thresh = '0;
  logic        fifo_pop = 1'b0;
  logic        mem_ack = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic        mem_req;
  logic [28:0] mem_addr;
  logic [1:0]  mem_size;
  logic [2:0]  mem_cs;
  logic [31:0] fifo_rdata;
  logic [LVL_W-1:0] fifo_level;
  logic        fifo_underflow, irq, dma_req, stat_busy;
  logic [1:0]  stat_active;
  logic [31:0] set0_addr, set1_addr;

  int n_vec = 0, n_bad = 0;
  logic hold = 1'b0;
  int   lat_cnt = 0;

  always #2 clk = ~clk;

  posted_rd_engine dut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_set(cfg_set),
    .cfg_field(cfg_field), .cfg_wdata(cfg_wdata), .cs_multi(cs_multi),
    .fifo_thresh(fifo_thresh), .fifo_pop(fifo_pop), .mem_ack(mem_ack),
    .mem_rdata(mem_rdata), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_size(mem_size), .mem_cs(mem_cs), .fifo_rdata(fifo_rdata),
    .fifo_level(fifo_level), .fifo_underflow(fifo_underflow), .irq(irq),
    .dma_req(dma_req), .stat_active(stat_active), .stat_busy(stat_busy),
    .set0_addr(set0_addr), .set1_addr(set1_addr)
  );

  // memory model: acknowledge two cycles after request unless held
  initial begin
    forever begin
      @(negedge clk);
      if (mem_ack) mem_ack = 1'b0;
      else if (mem_req && !hold) begin
        if (lat_cnt == 2) begin
          mem_ack   = 1'b1;
          mem_rdata = {mem_cs, mem_addr} ^ XMASK;
          lat_cnt   = 0;
        end else lat_cnt++;
      end
    end
  end

  function automatic logic [31:0] exp_data(input logic [31:0] a, input logic multi);
    return {multi ? a[31:29] : 3'b001, a[28:0]} ^ XMASK;
  endfunction

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic s, input logic [1:0] f, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_set = s; cfg_field = f; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic arm(input logic s, input logic [31:0] a, input logic [1:0] sz, input int n);
    wr(s, 2'd0, a);
    wr(s, 2'd1, {30'd0, sz});
    wr(s, 2'd2, n);
  endtask

  task automatic pop(output logic [31:0] d);
    @(negedge clk);
    fifo_pop = 1'b1;
    @(negedge clk);
    fifo_pop = 1'b0;
    d = fifo_rdata;
  endtask

  task automatic wait_idle();
    int quiet = 0;
    for (int i = 0; i < 3000 && quiet < 3; i++) begin
      @(negedge clk);
      if (!mem_req && stat_active == 2'b00) quiet++;
      else quiet = 0;
    end
  endtask

  task automatic wait_req();
    for (int i = 0; i < 100 && !mem_req; i++) @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1 mem_req", mem_req, 0);
    chk("R1 active/busy", {stat_active, stat_busy}, 0);
    chk("R1 level", fifo_level, 0);
    chk("R1 flags", {fifo_underflow, irq, dma_req}, 0);
  endtask

  task automatic t_basic();
    logic [31:0] d;
    fifo_thresh = 4'd3;
    arm(1'b0, 32'h100, 2'd2, 4);
    wait_req();
    chk("R2 size code word", mem_size, 2);
    chk("R9 single cs", mem_cs, 3'b001);
    wait_idle();
    chk("R3 level after 4", fifo_level, 4);
    chk("R2 addr advance", set0_addr, 32'h110);
    chk("R5 dma at thresh", dma_req, 1);
    chk("R5 irq at thresh", irq, 1);
    for (int i = 0; i < 2; i++) begin
      pop(d);
      chk("R3 data", d, exp_data(32'h100 + 4 * i, 1'b0));
    end
    repeat (2) @(negedge clk);
    chk("R5 dma below", dma_req, 0);
    chk("R5 irq below", irq, 0);
    for (int i = 2; i < 4; i++) begin
      pop(d);
      chk("R3 data", d, exp_data(32'h100 + 4 * i, 1'b0));
    end
  endtask

  task automatic t_sizes();
    logic [31:0] d;
    arm(1'b0, 32'h40, 2'd0, 3);
    wait_req();
    chk("R2 size code byte", mem_size, 0);
    wait_idle();
    chk("R2 byte step", set0_addr, 32'h43);
    for (int i = 0; i < 3; i++) begin
      pop(d);
      chk("R2 byte data", d, exp_data(32'h40 + i, 1'b0));
    end
    arm(1'b1, 32'h80, 2'd1, 2);
    wait_idle();
    chk("R2 half step", set1_addr, 32'h84);
    for (int i = 0; i < 2; i++) begin
      pop(d);
      chk("R2 half data", d, exp_data(32'h80 + 2 * i, 1'b0));
    end
  endtask

  task automatic t_full();
    logic [31:0] d;
    arm(1'b0, 32'h200, 2'd2, 12);
    repeat (150) @(negedge clk);
    chk("R4 level full", fifo_level, 8);
    chk("R4 no req when full", mem_req, 0);
    chk("R4 still active", stat_active, 2'b01);
    chk("R4 addr stalled", set0_addr, 32'h220);
    for (int i = 0; i < 12; i++) begin
      pop(d);
      chk("R4 data order", d, exp_data(32'h200 + 4 * i, 1'b0));
      repeat (10) @(negedge clk);
      if (i == 0) chk("R4 resumed", set0_addr, 32'h224);
    end
    wait_idle();
    chk("R4 final addr", set0_addr, 32'h230);
  endtask

  task automatic t_chain();
    logic [31:0] d;
    arm(1'b0, 32'h300, 2'd2, 5);
    arm(1'b1, 32'h400, 2'd2, 3);
    chk("R6 set0 running", stat_active, 2'b01);
    wait_idle();
    chk("R6 level", fifo_level, 8);
    for (int i = 0; i < 8; i++) begin
      pop(d);
      chk("R6 chained data", d,
          exp_data(i < 5 ? 32'h300 + 4 * i : 32'h400 + 4 * (i - 5), 1'b0));
    end
    chk("R6 set1 addr", set1_addr, 32'h40C);
  endtask

  task automatic t_reload();
    logic [31:0] d;
    arm(1'b0, 32'h500, 2'd2, 6);
    arm(1'b1, 32'h600, 2'd1, 2);
    chk("R7 set0 still running", stat_active, 2'b01);
    wait_idle();
    chk("R7 level", fifo_level, 8);
    for (int i = 0; i < 8; i++) begin
      pop(d);
      chk("R7 reload data", d,
          exp_data(i < 6 ? 32'h500 + 4 * i : 32'h600 + 2 * (i - 6), 1'b0));
    end
    chk("R7 set1 addr", set1_addr, 32'h604);
  endtask

  task automatic t_cancel();
    logic [31:0] d;
    logic [28:0] a0;
    hold = 1'b1;
    arm(1'b0, 32'h700, 2'd2, 5);
    wait_req();
    a0 = mem_addr;
    wr(1'b0, 2'd2, 32'd0);
    repeat (6) @(negedge clk);
    chk("R8 active+busy held", {stat_active, stat_busy}, 3'b011);
    chk("R10 addr stable", mem_addr, a0);
    chk("R8 nothing pushed yet", fifo_level, 0);
    hold = 1'b0;
    wait_idle();
    chk("R8 one entry", fifo_level, 1);
    chk("R8 addr one step", set0_addr, 32'h704);
    chk("R8 busy clear", stat_busy, 0);
    pop(d);
    chk("R8 inflight data", d, exp_data(32'h700, 1'b0));
  endtask

  task automatic t_cs();
    logic [31:0] d;
    cs_multi = 1'b1;
    arm(1'b0, 32'hA000_0010, 2'd2, 2);
    wait_req();
    chk("R9 multi cs", mem_cs, 3'b101);
    chk("R9 low addr", mem_addr, 29'h10);
    wait_idle();
    for (int i = 0; i < 2; i++) begin
      pop(d);
      chk("R9 data", d, exp_data(32'hA000_0010 + 4 * i, 1'b1));
    end
    cs_multi = 1'b0;
  endtask

  task automatic t_underflow();
    logic [31:0] d;
    chk("R11 empty first", fifo_level, 0);
    pop(d);
    chk("R11 zero data", d, 0);
    repeat (2) @(negedge clk);
    chk("R11 sticky flag", fifo_underflow, 1);
    chk("R11 irq", irq, 1);
    chk("R11 no dma", dma_req, 0);
    repeat (5) @(negedge clk);
    chk("R11 still set", fifo_underflow, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_basic();
    t_sizes();
    t_full();
    t_chain();
    t_reload();
    t_cancel();
    t_cs();
    t_underflow();
    summary();
  end
endmodule